// File: doc/BRIEF.md
# Serial Port Modem Line Controller

This block owns the modem handshake lines of a serial port. The host writes a control byte that sets Data Terminal Ready, Request To Send, two auxiliary outputs and an internal loopback switch. The block drives these onto active-low output pins. Four active-low input pins, Clear To Send, Data Set Ready, Ring Indicator and Data Carrier Detect, are synchronised to the core clock. The block reports them in a status byte that the host reads.

The upper half of the status byte shows the current level of each input line. The lower half holds sticky change flags. The flags for carrier detect, data set ready and clear to send catch every change of state. The ring flag catches only the moment the ring signal goes away. A status read clears the flags, but an event that lands in the same cycle as the read is kept. An interrupt-style output is high while any change flag is set. In loopback mode the external output pins are forced inactive. Each control output then feeds one status input, so host software can exercise the whole status path without a cable.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control byte reads 0x00, all four output pins are high, the status byte reads 0x00 while all input pins are high, and `chg_irq` is low.
- R2: The control byte reads back with bit 0 = DTR, bit 1 = RTS, bit 2 = OUT1, bit 3 = OUT2, bit 4 = loopback; bits 7..5 always read 0 whatever was written.
- R3: Outside loopback, each output pin is the inverse of its control bit. Writing 0x08 leaves DTR and RTS both inactive (high), 0x0A drives only RTS low, and 0x09 drives only DTR low.
- R4: Status bits 7,6,5,4 are the active (pin low) state of DCD, RI, DSR and CTS. A pin change appears in the status byte after SYNC_STAGES rising clock edges.
- R5: Status bit 3 (DCD), bit 1 (DSR) and bit 0 (CTS) set when that line changes state one or more times. Each stays set until a status read.
- R6: Status bit 2 sets only when the RI pin goes from low to high (ring ends). RI becoming active does not set it.
- R7: A status read (`sts_rd` high for one cycle) returns the byte with its flags, and the flags are clear from the next cycle.
- R8: A line change that is detected in the same cycle as a status read sets its flag again after that read, so the event is not lost.
- R9: In loopback, CTS follows RTS, DSR follows DTR, RI follows OUT1 and DCD follows OUT2, and changes made this way set the change flags as in R5 and R6.
- R10: In loopback all four output pins are high, and activity on the external input pins does not alter the status byte.
- R11: `chg_irq` is high exactly when any of status bits 3..0 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte to write |
| ctl_rdata | output | 8 | Current control byte |
| sts_rd | input | 1 | Status read strobe; clears change flags |
| sts_rdata | output | 8 | Status byte: line states 7..4, change flags 3..0 |
| pin_cts_n | input | 1 | Clear To Send pin, active low |
| pin_dsr_n | input | 1 | Data Set Ready pin, active low |
| pin_ri_n | input | 1 | Ring Indicator pin, active low |
| pin_dcd_n | input | 1 | Data Carrier Detect pin, active low |
| pin_dtr_n | output | 1 | Data Terminal Ready pin, active low |
| pin_rts_n | output | 1 | Request To Send pin, active low |
| pin_out1_n | output | 1 | Auxiliary output 1, active low |
| pin_out2_n | output | 1 | Auxiliary output 2, active low |
| chg_irq | output | 1 | High while any change flag is set |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default 2. A test that a pin change shows up neither one edge early nor one edge late can therefore only pass if the stage count comes from the parameter. The loopback path has no synchroniser delay. This lets the bench place a line change on exactly the cycle of a status read and observe the same-cycle retention rule. It also lets the bench create a ring trailing edge on demand by clearing the OUT1 bit.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int CTL_W   = 8;
    localparam int N_LINES = 4;
    localparam int RI_IDX  = 2;   // position of RI within line_t (dcd,ri,dsr,cts)

    typedef struct packed {
        logic [2:0] rsvd;
        logic       loop;
        logic       out2;
        logic       out1;
        logic       rts;
        logic       dtr;
    } ctl_t;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    typedef struct packed {
        line_t                now;
        logic [N_LINES-1:0]   chg;
    } sts_t;

    function automatic ctl_t ctl_from_byte(input logic [CTL_W-1:0] b);
        ctl_t c;
        c      = ctl_t'(b);
        c.rsvd = 3'b000;
        return c;
    endfunction

    function automatic line_t loop_route(input ctl_t c);
        line_t l;
        l.cts = c.rts;
        l.dsr = c.dtr;
        l.ri  = c.out1;
        l.dcd = c.out2;
        return l;
    endfunction

endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             out1_n,
    output logic             out2_n
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr)
            ctl_q <= ctl_from_byte(wdata);
    end

    always_comb begin
        ctl    = ctl_q;
        dtr_n  = ctl_q.loop | ~ctl_q.dtr;
        rts_n  = ctl_q.loop | ~ctl_q.rts;
        out1_n = ctl_q.loop | ~ctl_q.out1;
        out2_n = ctl_q.loop | ~ctl_q.out2;
    end
endmodule

// File: rtl/mdm_line_sync.sv
module mdm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic active
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '1;
        else
            sh_q <= {sh_q[STAGES-2:0], pin_n};
    end

    assign active = ~sh_q[STAGES-1];
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track
    import mdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  line_t              cur,
    input  logic               rd,
    output logic [N_LINES-1:0] chg
);
    line_t              prev_q;
    logic [N_LINES-1:0] ev;
    logic [N_LINES-1:0] chg_q;
    logic [N_LINES-1:0] cur_v;
    logic [N_LINES-1:0] prev_v;

    assign cur_v  = cur;
    assign prev_v = prev_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_ev
        if (i == RI_IDX) begin : g_trail
            assign ev[i] = prev_v[i] & ~cur_v[i];
        end else begin : g_any
            assign ev[i] = prev_v[i] ^ cur_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            chg_q  <= '0;
        end else begin
            prev_q <= cur;
            chg_q  <= rd ? ev : (chg_q | ev);
        end
    end

    assign chg = chg_q;
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             sts_rd,
    output logic [CTL_W-1:0] sts_rdata,
    input  logic             pin_cts_n,
    input  logic             pin_dsr_n,
    input  logic             pin_ri_n,
    input  logic             pin_dcd_n,
    output logic             pin_dtr_n,
    output logic             pin_rts_n,
    output logic             pin_out1_n,
    output logic             pin_out2_n,
    output logic             chg_irq
);
    ctl_t               ctl;
    line_t              ext_lines;
    line_t              cur_lines;
    logic [N_LINES-1:0] pins_n;
    logic [N_LINES-1:0] ext_v;
    logic [N_LINES-1:0] chg;
    sts_t               sts;

    mdm_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .ctl    (ctl),
        .dtr_n  (pin_dtr_n),
        .rts_n  (pin_rts_n),
        .out1_n (pin_out1_n),
        .out2_n (pin_out2_n)
    );

    assign pins_n = {pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        mdm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .pin_n  (pins_n[i]),
            .active (ext_v[i])
        );
    end

    assign ext_lines = line_t'(ext_v);
    assign cur_lines = ctl.loop ? loop_route(ctl) : ext_lines;

    mdm_delta_track u_delta (
        .clk (clk),
        .rst (rst),
        .cur (cur_lines),
        .rd  (sts_rd),
        .chg (chg)
    );

    always_comb begin
        sts.now = cur_lines;
        sts.chg = chg;
    end

    assign sts_rdata = sts;
    assign ctl_rdata = ctl;
    assign chg_irq   = |chg;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_rdata,
    input logic       sts_rd,
    input logic [7:0] sts_rdata,
    input logic       pin_dtr_n,
    input logic       pin_rts_n,
    input logic       pin_out1_n,
    input logic       pin_out2_n,
    input logic       chg_irq
);
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b0;
        else     wr_q <= ctl_wr;
    end

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[7:5] == 3'b000);

    p_dtr_pin_r3: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[4] |-> (pin_dtr_n == !ctl_rdata[0]) && (pin_rts_n == !ctl_rdata[1]));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (chg_irq && !sts_rd) |=> chg_irq);

    p_read_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && ctl_rdata[4] && !ctl_wr && !wr_q) |=> (sts_rdata[3:0] == 4'h0));

    p_loop_map_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[4] |-> (sts_rdata[4] == ctl_rdata[1]) && (sts_rdata[5] == ctl_rdata[0])
                      && (sts_rdata[6] == ctl_rdata[2]) && (sts_rdata[7] == ctl_rdata[3]));

    p_loop_pins_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[4] |-> (pin_dtr_n && pin_rts_n && pin_out1_n && pin_out2_n));

    p_irq_r11: assert property (@(posedge clk) disable iff (rst)
        chg_irq == (sts_rdata[3:0] != 4'h0));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr     (ctl_wr),
    .ctl_rdata  (ctl_rdata),
    .sts_rd     (sts_rd),
    .sts_rdata  (sts_rdata),
    .pin_dtr_n  (pin_dtr_n),
    .pin_rts_n  (pin_rts_n),
    .pin_out1_n (pin_out1_n),
    .pin_out2_n (pin_out2_n),
    .chg_irq    (chg_irq)
);

// File: tb/test_modem_ctl_stat.sv
`timescale 1ns/1ps
module test_modem_ctl_stat;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       pin_cts_n = 1'b1;
    logic       pin_dsr_n = 1'b1;
    logic       pin_ri_n  = 1'b1;
    logic       pin_dcd_n = 1'b1;
    logic       pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n;
    logic       chg_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    modem_ctl_stat #(.SYNC_STAGES(3)) i_modem_ctl_stat (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
        .pin_ri_n(pin_ri_n), .pin_dcd_n(pin_dcd_n),
        .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n),
        .pin_out1_n(pin_out1_n), .pin_out2_n(pin_out2_n),
        .chg_irq(chg_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wdata = v;
        ctl_wr    = 1'b1;
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic rd_sts(output logic [7:0] v);
        sts_rd = 1'b1;
        v      = sts_rdata;
        @(negedge clk);
        sts_rd = 1'b0;
    endtask

    function automatic logic [7:0] pins_out();
        return {4'h0, pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n};
    endfunction

    task automatic t_reset();
        check("R1 ctl", ctl_rdata, 8'h00);
        check("R1 pins", pins_out(), 8'h0F);
        check("R1 sts", sts_rdata, 8'h00);
        check("R1 irq", {7'h0, chg_irq}, 8'h00);
    endtask

    task automatic t_control();
        wr_ctl(8'hEF);
        check("R2 readback", ctl_rdata, 8'h0F);
        check("R3 all low", pins_out(), 8'h00);
        wr_ctl(8'h08);
        check("R3 0x08", pins_out(), 8'h07);
        wr_ctl(8'h0A);
        check("R3 0x0A", pins_out(), 8'h05);
        wr_ctl(8'h09);
        check("R3 0x09", pins_out(), 8'h06);
        wr_ctl(8'hE0);
        check("R2 rsvd", ctl_rdata, 8'h00);
    endtask

    task automatic t_inputs();
        logic [7:0] v;
        pin_cts_n = 1'b0;
        cycles(2);
        check("R4 early", sts_rdata, 8'h00);
        cycles(1);
        check("R4 on time", sts_rdata, 8'h10);
        cycles(1);
        check("R5 dcts", sts_rdata, 8'h11);
        check("R11 irq set", {7'h0, chg_irq}, 8'h01);
        rd_sts(v);
        check("R7 read value", v, 8'h11);
        check("R7 cleared", sts_rdata, 8'h10);
        check("R11 irq clr", {7'h0, chg_irq}, 8'h00);
        pin_dsr_n = 1'b0;
        pin_dcd_n = 1'b0;
        cycles(6);
        check("R4 R5 dcd dsr", sts_rdata, 8'hBA);
        rd_sts(v);
        pin_cts_n = 1'b1;
        cycles(6);
        pin_cts_n = 1'b0;
        cycles(6);
        check("R5 sticky", sts_rdata, 8'hB1);
        rd_sts(v);
        check("R7 after sticky", sts_rdata, 8'hB0);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        pin_ri_n = 1'b0;
        cycles(6);
        check("R6 leading", sts_rdata, 8'hF0);
        pin_ri_n = 1'b1;
        cycles(6);
        check("R6 trailing", sts_rdata, 8'hB4);
        rd_sts(v);
        pin_cts_n = 1'b1;
        pin_dsr_n = 1'b1;
        pin_dcd_n = 1'b1;
        cycles(6);
        check("R5 drop", sts_rdata, 8'h0B);
        rd_sts(v);
        check("R7 idle", sts_rdata, 8'h00);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        wr_ctl(8'h10);
        check("R10 pins", pins_out(), 8'h0F);
        cycles(1);
        check("R9 idle", sts_rdata, 8'h00);
        wr_ctl(8'h11);
        cycles(1);
        check("R9 dtr-dsr", sts_rdata, 8'h22);
        check("R10 pins dtr", pins_out(), 8'h0F);
        rd_sts(v);
        wr_ctl(8'h12);
        cycles(1);
        check("R9 rts-cts", sts_rdata, 8'h13);
        rd_sts(v);
        wr_ctl(8'h14);
        cycles(1);
        check("R9 out1-ri", sts_rdata, 8'h41);
        rd_sts(v);
        wr_ctl(8'h18);
        cycles(1);
        check("R9 R6 out2-dcd", sts_rdata, 8'h8C);
        rd_sts(v);
        check("R7 loop", sts_rdata, 8'h80);
        pin_cts_n = 1'b0;
        pin_dsr_n = 1'b0;
        cycles(6);
        check("R10 ignore", sts_rdata, 8'h80);
        pin_cts_n = 1'b1;
        pin_dsr_n = 1'b1;
        cycles(6);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        wr_ctl(8'h10);
        rd_sts(v);
        check("R8 read value", v, 8'h00);
        check("R8 kept", sts_rdata, 8'h08);
        rd_sts(v);
        check("R8 then clear", sts_rdata, 8'h00);
        wr_ctl(8'h00);
        cycles(2);
        check("R10 exit", sts_rdata, 8'h00);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        t_reset();
        t_control();
        t_inputs();
        t_ring();
        t_loop();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule